// File: doc/BRIEF.md
# Readout Card Block-Transfer Address Generator

This block sits on a readout card beside a 2048-word by 32-bit dual-port buffer. It drives the buffer's backplane-side port. While the card is selected, the backplane address drives that port directly. A single read of a reserved buffer location arms a block transfer. The word read there is the block's start address, and its control bit (bit 18 of the data lines) is clear. That word is captured from the data lines into a presettable counter on the same strobe. The captured control bit, inverted in sense, goes back to the crate controller as an active-low bus request.

From then on the counter steps once per bus clock and presents consecutive buffer addresses. The step after the top location carries into the control bit, which releases the request and leaves the address field at zero. A block therefore always runs from its start address to the last location, so no length register is needed. The card's local processor fills the buffer through a separate write path. That path is blocked while a transfer runs.

Top module: `rc_blkxfer_agen`

## Requirements
- R1: After reset, `dma_req_n` is 1, `xcvr_oe_n` is 1, `port_en` is 0 and `port_addr` is 0 (state IDLE).
- R2: A high `board_sel` sampled at a clock edge in IDLE moves the block to ACCESS, which drives `xcvr_oe_n` low. A low `board_sel` at an edge in ACCESS, with no arming strobe, returns it to IDLE and `xcvr_oe_n` to 1.
- R3: In ACCESS, `port_addr` equals `bus_addr` and `port_en` equals `bus_strobe`.
- R4: In ACCESS, a strobe with `bus_addr` equal to the reserved location (default 0) and `bus_data[18]` = 0 loads `bus_data[10:0]` into the counter. From the next cycle, `dma_req_n` is 0, `port_en` is 1 and `port_addr` shows the loaded start address (state DMA).
- R5: A strobe whose `bus_data[18]` is 1, or whose `bus_addr` is not the reserved location, starts no transfer: `dma_req_n` stays 1.
- R6: While `dma_req_n` is 0, `port_addr` increases by exactly one per clock.
- R7: In the cycle after `port_addr` 2047 is presented in DMA, `dma_req_n` returns to 1 and the counter's address field is 0. This is visible on `port_addr` in IDLE.
- R8: A transfer presents 2048 − start words: start 0 gives 2048 words, start 2047 gives exactly one.
- R9: `loc_ram_we` follows `loc_we` when no transfer is active and is 0 while `dma_req_n` is 0. `loc_ram_addr` and `loc_ram_wdata` pass through unchanged.
- R10: During DMA, `board_sel` and `bus_strobe` are ignored. The transfer runs to completion and `xcvr_oe_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_sel | input | 1 | Externally decoded card select |
| bus_strobe | input | 1 | Data strobe of a backplane access |
| bus_addr | input | 11 | Backplane word address into the buffer |
| bus_data | input | 32 | Data lines seen during the strobe |
| loc_we | input | 1 | Local processor write request |
| loc_addr | input | 11 | Local write address |
| loc_wdata | input | 32 | Local write data |
| port_addr | output | 11 | Address for the buffer's backplane port |
| port_en | output | 1 | Buffer backplane port enable |
| dma_req_n | output | 1 | Active-low bus request to the controller |
| xcvr_oe_n | output | 1 | Active-low backplane transceiver enable |
| loc_ram_we | output | 1 | Gated write enable to the local port |
| loc_ram_addr | output | 11 | Local port address |
| loc_ram_wdata | output | 32 | Local port write data |

## Verification
A wrong counter value shows on `port_addr` in the very next DMA cycle, because the counter drives that output directly. A wrong control bit shows on `dma_req_n` one edge after the arming strobe or after the final word. A wrong state shows within one cycle: either `xcvr_oe_n` changes, or `port_addr` switches between the bus address and the count. The bench compares every output on every clock with a behavioural model, so any such error is reported in the cycle it first reaches a port.

// File: rtl/rc_blkxfer_pkg.sv
package rc_blkxfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DMA    = 2'd2
    } agen_state_e;
endpackage

// File: rtl/rc_blkxfer_counter.sv
module rc_blkxfer_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    input  logic [ADDR_W:0]   load_val,
    output logic [ADDR_W:0]   q
);
    localparam logic [ADDR_W:0] RESET_VAL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE       = {{ADDR_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (load)
            q <= load_val;
        else if (inc)
            q <= q + ONE;
    end
endmodule

// File: rtl/rc_blkxfer_fsm.sv
module rc_blkxfer_fsm
    import rc_blkxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        board_sel,
    input  logic        bus_strobe,
    input  logic        arm_match,
    input  logic        last_word,
    output agen_state_e state,
    output logic        load,
    output logic        inc,
    output logic        oe_n,
    output logic        port_en
);
    agen_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (board_sel) state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (bus_strobe && arm_match) state_d = ST_DMA;
                else if (!board_sel)         state_d = ST_IDLE;
            end
            ST_DMA:    if (last_word) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        load    = 1'b0;
        inc     = 1'b0;
        oe_n    = 1'b1;
        port_en = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ACCESS: begin
                oe_n    = 1'b0;
                port_en = bus_strobe;
                load    = bus_strobe && arm_match;
            end
            ST_DMA: begin
                oe_n    = 1'b0;
                port_en = 1'b1;
                inc     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rc_blkxfer_local.sv
module rc_blkxfer_local #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              busy,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              we_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out
);
    assign we_out    = we_in & ~busy;
    assign addr_out  = addr_in;
    assign wdata_out = wdata_in;
endmodule

// File: rtl/rc_blkxfer_agen.sv
module rc_blkxfer_agen
    import rc_blkxfer_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 32,
    parameter int CTRL_POS  = 18,
    parameter int START_LOC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              board_sel,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_en,
    output logic              dma_req_n,
    output logic              xcvr_oe_n,
    output logic              loc_ram_we,
    output logic [ADDR_W-1:0] loc_ram_addr,
    output logic [DATA_W-1:0] loc_ram_wdata
);
    localparam logic [ADDR_W-1:0] START_A  = ADDR_W'(START_LOC);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    agen_state_e      state;
    logic             load, inc, arm_match, last_word;
    logic [ADDR_W:0]  cnt;

    // Arming read: reserved location, control bit clear on the data lines.
    assign arm_match = (bus_addr == START_A) && !bus_data[CTRL_POS];
    assign last_word = (cnt[ADDR_W-1:0] == TOP_ADDR);

    rc_blkxfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .board_sel  (board_sel),
        .bus_strobe (bus_strobe),
        .arm_match  (arm_match),
        .last_word  (last_word),
        .state      (state),
        .load       (load),
        .inc        (inc),
        .oe_n       (xcvr_oe_n),
        .port_en    (port_en)
    );

    rc_blkxfer_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .inc      (inc),
        .load_val ({bus_data[CTRL_POS], bus_data[ADDR_W-1:0]}),
        .q        (cnt)
    );

    // The latched control bit is the request, low while a block runs.
    assign dma_req_n = cnt[ADDR_W];
    assign port_addr = (state == ST_ACCESS) ? bus_addr : cnt[ADDR_W-1:0];

    rc_blkxfer_local #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_loc (
        .busy      (~dma_req_n),
        .we_in     (loc_we),
        .addr_in   (loc_addr),
        .wdata_in  (loc_wdata),
        .we_out    (loc_ram_we),
        .addr_out  (loc_ram_addr),
        .wdata_out (loc_ram_wdata)
    );
endmodule

// File: rtl/rc_blkxfer_agen_chk.sv
module rc_blkxfer_agen_chk
    import rc_blkxfer_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 32,
    parameter int CTRL_POS  = 18,
    parameter int START_LOC = 0
) (
    input logic              clk,
    input logic              rst_n,
    input agen_state_e       state,
    input logic              bus_strobe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic [ADDR_W-1:0] port_addr,
    input logic              dma_req_n,
    input logic              xcvr_oe_n,
    input logic              loc_ram_we
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] START_A  = ADDR_W'(START_LOC);

    assert_state_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DMA) == !dma_req_n);

    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && bus_strobe && bus_addr == START_A && !bus_data[CTRL_POS])
        |=> (!dma_req_n && port_addr == $past(bus_data[ADDR_W-1:0])));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req_n && port_addr != TOP_ADDR)
        |=> (!dma_req_n && port_addr == $past(port_addr) + ADDR_W'(1)));

    assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req_n && port_addr == TOP_ADDR)
        |=> (dma_req_n && port_addr == '0));

    assert_no_local_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_n |-> !loc_ram_we);

    assert_drivers_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_n |-> !xcvr_oe_n);
endmodule

bind rc_blkxfer_agen rc_blkxfer_agen_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_POS(CTRL_POS), .START_LOC(START_LOC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .bus_strobe (bus_strobe),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .port_addr  (port_addr),
    .dma_req_n  (dma_req_n),
    .xcvr_oe_n  (xcvr_oe_n),
    .loc_ram_we (loc_ram_we)
);

// File: tb/test_rc_blkxfer_agen.sv
module test_rc_blkxfer_agen;
    localparam int CLK_P = 10;
    localparam int AW = 11;
    localparam int DW = 32;

    logic clk = 0, rst_n = 0;
    logic board_sel = 0, bus_strobe = 0, loc_we = 0;
    logic [AW-1:0] bus_addr = '0, loc_addr = '0;
    logic [DW-1:0] bus_data = '0, loc_wdata = '0;
    logic [AW-1:0] port_addr, loc_ram_addr;
    logic [DW-1:0] loc_ram_wdata;
    logic port_en, dma_req_n, xcvr_oe_n, loc_ram_we;

    int checks = 0, fails = 0, words = 0;

    // behavioural model: 0 idle, 1 access, 2 dma
    int m_st = 0, m_addr = 0, m_req = 1;

    always #(CLK_P/2) clk = ~clk;

    rc_blkxfer_agen i_rc_blkxfer_agen (
        .clk(clk), .rst_n(rst_n), .board_sel(board_sel), .bus_strobe(bus_strobe),
        .bus_addr(bus_addr), .bus_data(bus_data), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .port_addr(port_addr),
        .port_en(port_en), .dma_req_n(dma_req_n), .xcvr_oe_n(xcvr_oe_n),
        .loc_ram_we(loc_ram_we), .loc_ram_addr(loc_ram_addr),
        .loc_ram_wdata(loc_ram_wdata)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_req = 1;
        end else begin
            case (m_st)
                0: if (board_sel) m_st = 1;
                1: begin
                    if (bus_strobe && bus_addr == 0 && !bus_data[18]) begin
                        m_addr = int'(bus_data[10:0]); m_req = 0; m_st = 2;
                    end else if (!board_sel) m_st = 0;
                end
                default: begin
                    if (m_addr == 2047) begin m_addr = 0; m_req = 1; m_st = 0; end
                    else m_addr++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 req", int'(dma_req_n), m_req);
            chk("R2 oe", int'(xcvr_oe_n), (m_st == 0) ? 1 : 0);
            chk("R3 addr", int'(port_addr), (m_st == 1) ? int'(bus_addr) : m_addr);
            chk("R6 en", int'(port_en), (m_st == 2 || (m_st == 1 && bus_strobe)) ? 1 : 0);
            chk("R9 we", int'(loc_ram_we), (loc_we && m_st != 2) ? 1 : 0);
            if (!dma_req_n) words++;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic run_block(int start, bit drop_sel);
        bus_addr = '0; bus_data = '0; bus_data[10:0] = start[10:0];
        bus_strobe = 1; words = 0;
        step();
        bus_strobe = 0; bus_addr = 11'd33;
        if (drop_sel) board_sel = 0;
        for (int i = 0; i < 2100 && !dma_req_n; i++) @(negedge clk);
        #2;
        chk("R8 words", words, 2048 - start);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1; #2;
        chk("R1 req", int'(dma_req_n), 1);
        chk("R1 oe", int'(xcvr_oe_n), 1);
        chk("R1 en", int'(port_en), 0);
        chk("R1 addr", int'(port_addr), 0);
        // R9: local write passes in idle
        loc_we = 1; loc_addr = 11'd9; loc_wdata = 32'hA5A5_0001; #1;
        chk("R9 pass", int'(loc_ram_we), 1);
        chk("R9 addr", int'(loc_ram_addr), 9);
        loc_we = 0;
        // R2 select
        step(); board_sel = 1; step(); #1;
        chk("R2 oe low", int'(xcvr_oe_n), 0);
        // R3 random access
        bus_addr = 11'd5; bus_strobe = 1; #1;
        chk("R3 addr", int'(port_addr), 5);
        chk("R3 en", int'(port_en), 1);
        // R5: control bit set at reserved location
        bus_addr = '0; bus_data = 32'h0004_0010; step();
        bus_strobe = 0; step();
        chk("R5 ctrl", int'(dma_req_n), 1);
        // R5: other address with control bit clear
        bus_addr = 11'd7; bus_data = 32'h0000_0010; bus_strobe = 1; step();
        bus_strobe = 0; step();
        chk("R5 addr", int'(dma_req_n), 1);
        // R2 deselect
        board_sel = 0; step(); #1;
        chk("R2 oe high", int'(xcvr_oe_n), 1);
        // R4/R10: short block, strobes and local writes ignored, select dropped
        board_sel = 1; step();
        fork
            run_block(2040, 1'b1);
            begin
                step(); step();
                loc_we = 1; bus_strobe = 1; bus_addr = '0; bus_data = 32'h0000_0100;
                #1 chk("R9 blocked", int'(loc_ram_we), 0);
                chk("R10 oe", int'(xcvr_oe_n), 0);
                step(); loc_we = 0; bus_strobe = 0;
            end
        join
        // R7: ends in idle with address zero
        chk("R7 req", int'(dma_req_n), 1);
        chk("R7 addr", int'(port_addr), 0);
        // R8 single-word block
        board_sel = 1; step();
        run_block(2047, 1'b0);
        // R8 full buffer
        board_sel = 1; step();
        run_block(0, 1'b1);
        chk("R7 zero", int'(port_addr), 0);
        step(); step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule